// File: doc/BRIEF.md
# Torus Mesh Packet Router Node

This block is the switching element for one node of an 8-column by 7-row network whose links wrap around at both edges. Packets are 128 bits wide and cross every link as 32 nibbles under a valid/ready handshake. Four ring links enter the node: from the west neighbour, from the east neighbour, from the south neighbour and from the north neighbour. Four ring links leave it, one toward each of those neighbours. The node's own processor reaches the router through a parallel transmit register and a parallel receive register. The receive register has a status flag that software can poll.

Each ring input and the transmit register feed a one-packet holding buffer. A round-robin switch scans these five buffers and moves one whole packet per cycle. Each packet goes to one of three places: an idle output serializer, the receive register, or the discard path. A packet addressed to this node is delivered unchanged. Any other packet is forwarded with its age byte incremented, or dropped and counted if its age is already at the maximum. Routing corrects the column first and then the row. On each axis it takes the shorter way around the ring. The node's own column and row come in on strap inputs.

Top module: `torus_router_node`

## Requirements
- R1: While reset is held and after it is released, every `out_valid` bit is low, every `in_ready` bit is high, `rx_flag` and `tx_full` are low, and `drop_count` is zero.
- R2: A packet crosses a link as 32 nibbles, most significant nibble first. Link bit group k is `data[4k+3:4k]`. Link indices are 0 = +X (east), 1 = -X (west), 2 = +Y (north), 3 = -Y (south). A nibble moves only in a cycle where valid and ready are both high. While an output is stalled, its data holds.
- R3: The destination sits in packet bits [127:116], with the column in bits [127:124] and the row in bits [123:120]. The age sits in bits [103:96]. Destination bits [119:116] and the remaining bits are carried through without being interpreted.
- R4: A packet whose destination column and row equal `node_col` and `node_row` is placed in `rx_pkt` unchanged, and `rx_flag` is set. This holds whatever the packet's age.
- R5: When the destination column differs from `node_col`, let dx = (dest_col - node_col) mod 8. The packet leaves on link 0 if dx <= 4 and on link 1 otherwise. A tie at dx = 4 therefore goes to link 0.
- R6: When the columns match and the rows differ, let dy = (dest_row - node_row) mod 7. The packet leaves on link 2 if dy <= 3 and on link 3 otherwise.
- R7: A forwarded packet leaves with its age byte incremented by one and every other bit unchanged.
- R8: A packet that would be forwarded while its age is 8'hFF is discarded. It appears on no output, `drop_count` rises by one, and its input link's `in_ready` returns high.
- R9: While `rx_flag` is set, a further packet for this node stays in its input buffer and that link's `in_ready` stays low. A one-cycle `rx_read` pulse clears the flag, after which the held packet is delivered.
- R10: When two buffered packets need the same busy output, exactly one input link keeps `in_ready` low. Both packets later leave on that output.
- R11: `tx_load` captures `tx_pkt` only while `tx_full` is low. `tx_full` stays high until the packet has been switched, and a `tx_load` while it is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_col | input | 4 | This node's column (0..7) |
| node_row | input | 4 | This node's row (0..6) |
| in_valid | input | 4 | Ring input nibble valid, one bit per link |
| in_data | input | 16 | Ring input nibbles, 4 bits per link |
| in_ready | output | 4 | Ring input ready, low while the link's buffer is occupied |
| out_valid | output | 4 | Ring output nibble valid |
| out_data | output | 16 | Ring output nibbles, 4 bits per link |
| out_ready | input | 4 | Ring output ready from the neighbour |
| tx_load | input | 1 | Write strobe for the transmit register |
| tx_pkt | input | 128 | Packet to inject |
| tx_full | output | 1 | Transmit register occupied |
| rx_read | input | 1 | Read strobe, clears `rx_flag` |
| rx_pkt | output | 128 | Last packet delivered to this node |
| rx_flag | output | 1 | A delivered packet is waiting |
| drop_count | output | 16 | Number of packets discarded for age |

## Verification
Some rules are checked by assertions on every cycle:
- a buffer fills only after an accepted nibble;
- a stalled output keeps its nibble;
- the receive register cannot change while its flag is pending;
- the discard counter never moves by more than one.

Other behaviour can only be shown by the bench's scenarios. These cover the routing decisions, including the wraparound and tie cases, the age increment, the age-based drop, and the hold of a second local packet. They also cover one-winner contention and the ignored transmit write. The bench sweeps every destination from four node positions and compares each result against arithmetic it computes itself.

// File: rtl/torus_pkg.sv
package torus_pkg;
  localparam int PKT_W   = 128;
  localparam int NIB_W   = 4;
  localparam int AGE_W   = 8;
  localparam int CRD_W   = 4;
  localparam int DST_LSB = 116;
  localparam int AGE_LSB = 96;
  localparam int COL_LSB = 8;
  localparam int ROW_LSB = 4;
  localparam int NRING   = 4;
  localparam int NSRC    = NRING + 1;
  localparam int SRC_W   = $clog2(NSRC);

  typedef enum logic [2:0] {
    TGT_XP   = 3'd0,
    TGT_XN   = 3'd1,
    TGT_YP   = 3'd2,
    TGT_YN   = 3'd3,
    TGT_LOC  = 3'd4,
    TGT_DROP = 3'd5
  } tgt_e;
endpackage

// File: rtl/trn_link_rx.sv
module trn_link_rx #(
  parameter int PKT_W = 128,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NIB_W-1:0] in_data,
  output logic             in_ready,
  input  logic             take,
  output logic             full,
  output logic [PKT_W-1:0] pkt
);
  localparam int NN = PKT_W / NIB_W;
  localparam int CW = $clog2(NN);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             full_q, full_d;
  logic [PKT_W-1:0] sh_q, sh_d;
  logic             acc;

  assign acc = in_valid && !full_q;

  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    sh_d   = sh_q;
    if (acc) begin
      sh_d = {sh_q[PKT_W-NIB_W-1:0], in_data};
      if (cnt_q == CW'(NN - 1)) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (take) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) sh_q <= sh_d;
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign pkt      = sh_q;

  // R2: the buffer can only fill on a cycle that accepted a nibble
  a_r2_fill_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/trn_link_tx.sv
module trn_link_tx #(
  parameter int PKT_W = 128,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PKT_W-1:0] pkt_in,
  output logic             busy,
  output logic             out_valid,
  output logic [NIB_W-1:0] out_data,
  input  logic             out_ready
);
  localparam int NN = PKT_W / NIB_W;
  localparam int CW = $clog2(NN);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic [PKT_W-1:0] sh_q, sh_d;
  logic             fire, sh_en;

  assign fire  = busy_q && out_ready;
  assign sh_en = load || fire;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    sh_d   = sh_q;
    if (load) begin
      sh_d   = pkt_in;
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (fire) begin
      sh_d = {sh_q[PKT_W-NIB_W-1:0], {NIB_W{1'b0}}};
      if (cnt_q == CW'(NN - 1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (sh_en) sh_q <= sh_d;
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_data  = sh_q[PKT_W-1 -: NIB_W];

  // R2: a stalled output keeps presenting the same nibble
  a_r2_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/trn_route.sv
module trn_route
  import torus_pkg::*;
#(
  parameter int COLS = 8,
  parameter int ROWS = 7
) (
  input  logic [PKT_W-1:0] pkt,
  input  logic [CRD_W-1:0] node_col,
  input  logic [CRD_W-1:0] node_row,
  output tgt_e             tgt
);
  localparam int DW = CRD_W + 1;

  logic [DW-1:0] dc, dr, cc, cr, dx, dy;
  logic          age_max;

  assign dc = {1'b0, pkt[DST_LSB+COL_LSB +: CRD_W]};
  assign dr = {1'b0, pkt[DST_LSB+ROW_LSB +: CRD_W]};
  assign cc = {1'b0, node_col};
  assign cr = {1'b0, node_row};
  assign dx = (dc >= cc) ? (dc - cc) : (dc + DW'(COLS) - cc);
  assign dy = (dr >= cr) ? (dr - cr) : (dr + DW'(ROWS) - cr);
  assign age_max = &pkt[AGE_LSB +: AGE_W];

  always_comb begin
    if (dx != '0)
      tgt = ({dx, 1'b0} <= (DW+1)'(COLS)) ? TGT_XP : TGT_XN;
    else if (dy != '0)
      tgt = ({dy, 1'b0} <= (DW+1)'(ROWS)) ? TGT_YP : TGT_YN;
    else
      tgt = TGT_LOC;
    if (tgt != TGT_LOC && age_max) tgt = TGT_DROP;
  end
endmodule

// File: rtl/torus_router_node.sv
module torus_router_node
  import torus_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int ROWS  = 7,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CRD_W-1:0]       node_col,
  input  logic [CRD_W-1:0]       node_row,
  input  logic [NRING-1:0]       in_valid,
  input  logic [NRING*NIB_W-1:0] in_data,
  output logic [NRING-1:0]       in_ready,
  output logic [NRING-1:0]       out_valid,
  output logic [NRING*NIB_W-1:0] out_data,
  input  logic [NRING-1:0]       out_ready,
  input  logic                   tx_load,
  input  logic [PKT_W-1:0]       tx_pkt,
  output logic                   tx_full,
  input  logic                   rx_read,
  output logic [PKT_W-1:0]       rx_pkt,
  output logic                   rx_flag,
  output logic [CNT_W-1:0]       drop_count
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic [NSRC-1:0]  src_full, take, tgt_ok;
  logic [PKT_W-1:0] src_pkt [NSRC];
  tgt_e             src_tgt [NSRC];
  logic [NRING-1:0] ser_busy, ld;
  logic             gv;
  logic [SRC_W-1:0] gi, rr_q, rr_d;
  logic [2:0]       gtgt;
  logic [PKT_W-1:0] gpkt, fwd_pkt;
  logic             lt_full_q, lt_full_d;
  logic [PKT_W-1:0] lt_pkt_q, rx_pkt_q;
  logic             rx_flag_q, rx_flag_d;
  logic [CNT_W-1:0] drop_q, drop_d;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    trn_link_rx #(.PKT_W(PKT_W), .NIB_W(NIB_W)) u_rx (
      .clk(clk), .rst_n(rst_s),
      .in_valid(in_valid[g]), .in_data(in_data[NIB_W*g +: NIB_W]),
      .in_ready(in_ready[g]), .take(take[g]),
      .full(src_full[g]), .pkt(src_pkt[g]));

    trn_link_tx #(.PKT_W(PKT_W), .NIB_W(NIB_W)) u_tx (
      .clk(clk), .rst_n(rst_s), .load(ld[g]), .pkt_in(fwd_pkt),
      .busy(ser_busy[g]), .out_valid(out_valid[g]),
      .out_data(out_data[NIB_W*g +: NIB_W]), .out_ready(out_ready[g]));

    assign ld[g] = gv && (gtgt == 3'(g));
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    trn_route #(.COLS(COLS), .ROWS(ROWS)) u_route (
      .pkt(src_pkt[g]), .node_col(node_col), .node_row(node_row),
      .tgt(src_tgt[g]));
    assign take[g] = gv && (gi == SRC_W'(g));
  end

  // local transmit register acts as the fifth source
  assign src_full[NRING] = lt_full_q;
  assign src_pkt[NRING]  = lt_pkt_q;
  assign tx_full         = lt_full_q;

  always_comb begin
    lt_full_d = lt_full_q;
    if (take[NRING]) lt_full_d = 1'b0;
    if (tx_load && !lt_full_q) lt_full_d = 1'b1;
  end

  // which targets can accept a packet this cycle
  always_comb begin
    for (int j = 0; j < NSRC; j++) begin
      logic [2:0] tb;
      tb = src_tgt[j];
      if (src_tgt[j] == TGT_LOC)       tgt_ok[j] = !rx_flag_q;
      else if (src_tgt[j] == TGT_DROP) tgt_ok[j] = 1'b1;
      else                             tgt_ok[j] = !ser_busy[tb[1:0]];
    end
  end

  // round-robin scan starting at rr_q, one grant per cycle
  always_comb begin
    gv = 1'b0;
    gi = '0;
    for (int i = 0; i < NSRC; i++) begin
      int j;
      j = int'(rr_q) + i;
      if (j >= NSRC) j = j - NSRC;
      if (!gv && src_full[j] && tgt_ok[j]) begin
        gv = 1'b1;
        gi = SRC_W'(j);
      end
    end
  end

  assign gtgt = src_tgt[gi];
  assign gpkt = src_pkt[gi];

  always_comb begin
    fwd_pkt = gpkt;
    fwd_pkt[AGE_LSB +: AGE_W] = gpkt[AGE_LSB +: AGE_W] + 1'b1;
  end

  always_comb begin
    rr_d      = rr_q;
    rx_flag_d = rx_flag_q;
    drop_d    = drop_q;
    if (gv) rr_d = (gi == SRC_W'(NSRC - 1)) ? '0 : gi + 1'b1;
    if (rx_read) rx_flag_d = 1'b0;
    if (gv && gtgt == TGT_LOC)  rx_flag_d = 1'b1;
    if (gv && gtgt == TGT_DROP) drop_d = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rr_q      <= '0;
      rx_flag_q <= 1'b0;
      drop_q    <= '0;
      lt_full_q <= 1'b0;
    end else begin
      rr_q      <= rr_d;
      rx_flag_q <= rx_flag_d;
      drop_q    <= drop_d;
      lt_full_q <= lt_full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_load && !lt_full_q)  lt_pkt_q <= tx_pkt;
    if (gv && gtgt == TGT_LOC)  rx_pkt_q <= gpkt;
  end

  assign rx_flag    = rx_flag_q;
  assign rx_pkt     = rx_pkt_q;
  assign drop_count = drop_q;

  // R9: a pending receive register is never overwritten
  a_r9_rx_held_stable: assert property (@(posedge clk) disable iff (!rst_s)
    (rx_flag && $past(rx_flag) && !$past(rx_read)) |-> $stable(rx_pkt));

  // R8: the discard counter advances by exactly one at a time
  a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_s)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));
endmodule

// File: tb/torus_router_node_tb_top.sv
`timescale 1ns/1ps
module torus_router_node_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   node_col, node_row;
  logic [3:0]   in_valid;
  logic [15:0]  in_data;
  logic [3:0]   in_ready, out_valid, out_ready;
  logic [15:0]  out_data;
  logic         tx_load, tx_full, rx_read, rx_flag;
  logic [127:0] tx_pkt, rx_pkt;
  logic [15:0]  drop_count;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  torus_router_node dut_i (
    .clk(clk), .rst_n(rst_n), .node_col(node_col), .node_row(node_row),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .tx_load(tx_load), .tx_pkt(tx_pkt), .tx_full(tx_full),
    .rx_read(rx_read), .rx_pkt(rx_pkt), .rx_flag(rx_flag),
    .drop_count(drop_count));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input int dc, input int dr, input int age, input int tag);
    logic [31:0] t = 32'(tag);
    return {4'(dc), 4'(dr), 4'hF, 12'h3A7, 8'(age),
            t[15:0], t ^ 32'hC0DE_5A5A, t * 32'd1237, 16'h0A5A};
  endfunction

  function automatic logic [127:0] bump(input logic [127:0] p);
    logic [127:0] q = p;
    q[103:96] = p[103:96] + 8'd1;
    return q;
  endfunction

  function automatic int exp_port(input int cc, input int cr, input int dc, input int dr);
    int dx, dy;
    dx = (dc - cc + 8) % 8;
    dy = (dr - cr + 7) % 7;
    if (dx != 0) return (dx <= 4) ? 0 : 1;
    if (dy != 0) return (dy <= 3) ? 2 : 3;
    return 4;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_tx(input logic [127:0] p);
    @(negedge clk); tx_load = 1'b1; tx_pkt = p;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic rd_rx();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic send_link(input int k, input logic [127:0] p);
    int n = 0;
    while (n < 32) begin
      @(negedge clk);
      in_valid[k] = 1'b1;
      in_data[4*k +: 4] = p[127 - 4*n -: 4];
      if (in_ready[k]) begin
        @(posedge clk);
        n++;
      end
    end
    @(negedge clk);
    in_valid[k] = 1'b0;
  endtask

  // call at a negedge; samples, then steps one negedge per nibble
  task automatic collect(input int k, output logic [127:0] p, output bit ok);
    int n = 0;
    int t = 0;
    p = '0;
    while (n < 32 && t < 400) begin
      if (out_valid[k] && out_ready[k]) begin
        p = {p[123:0], out_data[4*k +: 4]};
        n++;
      end
      if (n < 32) @(negedge clk);
      t++;
    end
    ok = (n == 32);
  endtask

  initial begin
    logic [127:0] p, q, a, b, got;
    bit ok, seen;
    logic [3:0] d0;
    int ep;
    int cols[4] = '{0, 7, 3, 6};
    int rows[4] = '{0, 6, 3, 1};

    rst_n = 1'b0; in_valid = '0; in_data = '0; out_ready = 4'hF;
    tx_load = 1'b0; tx_pkt = '0; rx_read = 1'b0;
    node_col = 4'd0; node_row = 4'd0;
    wait_n(3);
    // R1 during reset
    chk(out_valid == 4'h0 && in_ready == 4'hF && !rx_flag && !tx_full && drop_count == 0,
        "R1 in reset", {out_valid, in_ready, rx_flag, tx_full, drop_count}, {4'h0, 4'hF, 18'h0});
    rst_n = 1'b1;
    wait_n(4);
    chk(out_valid == 4'h0 && in_ready == 4'hF && !rx_flag && !tx_full && drop_count == 0,
        "R1 after release", {out_valid, in_ready, rx_flag, tx_full, drop_count}, {4'h0, 4'hF, 18'h0});

    // R3 R4 R5 R6 R7 R2: sweep all destinations from four positions
    for (int s = 0; s < 4; s++) begin
      node_col = 4'(cols[s]); node_row = 4'(rows[s]);
      for (int dc = 0; dc < 8; dc++) begin
        for (int dr = 0; dr < 7; dr++) begin
          p  = mk(dc, dr, dc * 7 + dr, s * 100 + dc * 7 + dr);
          ep = exp_port(cols[s], rows[s], dc, dr);
          load_tx(p);
          if (ep == 4) begin
            seen = 1'b0;
            for (int i = 0; i < 50 && !seen; i++) begin
              if (rx_flag) seen = 1'b1; else @(negedge clk);
            end
            chk(seen && rx_pkt == p, "R4 local delivery", rx_pkt, p);
            rd_rx();
          end else begin
            collect(ep, got, ok);
            chk(ok && got == bump(p), "R5/R6/R7 route and age", got, bump(p));
          end
          wait_n(1);
        end
      end
    end

    // R2 stall hold, R11 transmit register
    node_col = 4'd2; node_row = 4'd2;
    out_ready[0] = 1'b0;
    a = mk(4, 2, 3, 901);
    b = mk(5, 3, 4, 902);
    load_tx(a);
    wait_n(3);
    d0 = out_data[3:0];
    wait_n(5);
    chk(out_valid[0] && out_data[3:0] == d0 && d0 == a[127:124], "R2 stall hold",
        {out_valid[0], out_data[3:0]}, {1'b1, a[127:124]});
    load_tx(b);
    wait_n(3);
    chk(tx_full == 1'b1, "R11 tx_full while pending", tx_full, 1);
    load_tx(mk(6, 0, 5, 903));
    out_ready[0] = 1'b1;
    collect(0, got, ok);
    chk(ok && got == bump(a), "R11 first packet", got, bump(a));
    wait_n(1);
    collect(0, got, ok);
    chk(ok && got == bump(b), "R11 pending packet kept", got, bump(b));
    seen = 1'b0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (out_valid != 4'h0 || rx_flag) seen = 1'b1;
    end
    chk(!seen && !tx_full, "R11 load while full ignored", {seen, tx_full}, 0);

    // R8 age drop
    p = mk(5, 5, 255, 904);
    send_link(1, p);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_valid != 4'h0) seen = 1'b1;
    end
    chk(!seen && drop_count == 16'd1 && in_ready[1], "R8 dropped at max age",
        {seen, drop_count, in_ready[1]}, {1'b0, 16'd1, 1'b1});
    p = mk(2, 2, 255, 905);
    send_link(3, p);
    wait_n(3);
    chk(rx_flag && rx_pkt == p && drop_count == 16'd1, "R8/R4 max age to self delivered", rx_pkt, p);
    rd_rx();

    // R9 second local packet held
    p = mk(2, 2, 10, 906);
    q = mk(2, 2, 11, 907);
    fork
      send_link(0, p);
      send_link(2, q);
    join
    wait_n(3);
    chk(rx_flag && ((in_ready[0] ^ in_ready[2]) == 1'b1), "R9 one held, ready low",
        {rx_flag, in_ready}, {1'b1, 4'b1010});
    got = rx_pkt;
    chk(got == p || got == q, "R9 first delivered", got, p);
    rd_rx();
    wait_n(3);
    chk(rx_flag && rx_pkt == ((got == p) ? q : p), "R9 held delivered after read",
        rx_pkt, (got == p) ? q : p);
    chk(in_ready == 4'hF, "R9 ready restored", in_ready, 4'hF);
    rd_rx();

    // R10 contention for one output
    out_ready[0] = 1'b0;
    p = mk(3, 2, 20, 908);
    q = mk(3, 5, 21, 909);
    fork
      send_link(1, p);
      send_link(3, q);
    join
    wait_n(3);
    chk((in_ready[1] ^ in_ready[3]) == 1'b1, "R10 exactly one link held", in_ready, 4'b0101);
    out_ready[0] = 1'b1;
    collect(0, a, ok);
    wait_n(1);
    collect(0, b, seen);
    chk(ok && seen && ((a == bump(p) && b == bump(q)) || (a == bump(q) && b == bump(p))),
        "R10 both packets delivered", a, bump(p));
    wait_n(3);
    chk(in_ready == 4'hF && out_valid == 4'h0, "R10 links idle after", {in_ready, out_valid}, 8'hF0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule